// File: doc/BRIEF.md
# Fault Mapping and Recovery Sequencer

This block watches a small set of upset-detection inputs and turns each one into a chosen combination of corrective actions. The actions are an output clamp, a processor halt, a primary reset, a secondary reset and a fault interrupt. A per-fault bit row in a programmable matrix selects the actions. A row left at zero masks that fault completely.

The two reset actions have programmable hold timers. These keep the reset asserted for a set number of slow ticks after the last fault that drives them goes away. While an outage lasts, an off-line timer measures its length on a slower tick. An event counter tallies unmasked fault edges, and a sticky status word records which inputs fired. These values remain readable after the outage, so recovery software can decide how to resume. Software programs the block through a plain write port made of a strobe, an address and data.

Top module: `fault_recovery_seq`

## Requirements
- R1: Each fault input passes through a two-flop synchronizer. A fault applied before clock edge k shows on the response outputs after edge k+1 and not after edge k.
- R2: Matrix bit f*5+j maps fault f to response j, with j ordered clamp=0, halt=1, primary reset=2, secondary reset=3, interrupt=4. A response output is high while any synchronized fault mapped to it is high. A fault whose five bits are all zero is masked and drives no response.
- R3: Each reset output stays high while a mapped fault is active. After the last mapped fault clears, it stays high for the programmed number of slow (1 MHz) ticks, and a programmed zero gives one tick. The two timers are independent.
- R4: The off-line timer restarts at zero when an outage begins. An outage is any unmasked fault active or either reset output high. The timer advances once per 100 kHz tick while the outage lasts, saturates at all-ones and holds its value after the outage ends.
- R5: The event counter adds one for every rising edge of an unmasked synchronized fault, so edges on two faults in the same cycle add two. Masked faults add nothing, and the counter saturates at all-ones instead of wrapping.
- R6: Status bits [N_FLT-1:0] are sticky and set on a rising edge of the matching synchronized fault, whether or not that fault is masked. Bits [N_FLT+4:N_FLT] show the live responses in R2 order, and the remaining bits read zero.
- R7: Writing with address 3 clears every sticky status bit whose data bit is one. A rising fault edge in the same cycle as the clear keeps its bit set.
- R8: Register writes select by address: 0 loads the matrix from data bits [19:0], 1 loads the primary reset length and 2 loads the secondary reset length.
- R9: After reset all outputs, the matrix, the timers, the counter and the status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_i | input | N_FLT | Asynchronous upset-detection inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 32 | Register write data |
| clamp_o | output | 1 | Output clamp response |
| halt_o | output | 1 | Processor halt response |
| prst_o | output | 1 | Timed primary reset |
| srst_o | output | 1 | Timed secondary reset |
| irq_o | output | 1 | Fault interrupt response |
| off_time_o | output | OFF_W | Length of last outage in 100 kHz ticks |
| evt_cnt_o | output | CNT_W | Saturating unmasked fault edge count |
| status_o | output | 32 | Sticky fault bits and live response vector |

## Verification
The sticky status update and the software clear can fall in the same cycle. The bench first clears a bit and then raises that fault. It times a clear write to land on the clock edge where the synchronized rising edge is detected, and expects the bit to stay set. A second collision is two unmasked faults rising together, which must advance the event counter by two in one step. A masked fault rising in the same cycle must add nothing to the counter but still set its status bit.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int unsigned N_RESP    = 5;
  localparam int unsigned RSP_CLAMP = 0;
  localparam int unsigned RSP_HALT  = 1;
  localparam int unsigned RSP_PRST  = 2;
  localparam int unsigned RSP_SRST  = 3;
  localparam int unsigned RSP_IRQ   = 4;
  localparam logic [1:0] ADDR_MTX  = 2'd0;
  localparam logic [1:0] ADDR_PLEN = 2'd1;
  localparam logic [1:0] ADDR_SLEN = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;
endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/fr_tick.sv
module fr_tick #(
  parameter int unsigned DIV = 66
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;
  assign tick_o = (cnt_q == CW'(DIV - 1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fr_rst_timer.sv
module fr_rst_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          tick_i,
  input  logic [TW-1:0] len_i,
  output logic          rst_o
);
  logic [TW-1:0] cnt_q, ld;
  assign ld = (len_i == '0) ? TW'(1) : len_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (act_i)                 cnt_q <= ld;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
  assign rst_o = act_i | (cnt_q != '0);
endmodule

// File: rtl/fault_recovery_seq.sv
module fault_recovery_seq
  import fr_pkg::*;
#(
  parameter int unsigned N_FLT    = 4,
  parameter int unsigned TMR_W    = 8,
  parameter int unsigned OFF_W    = 24,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned DIV_1M   = 66,
  parameter int unsigned DIV_100K = 660
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_FLT-1:0] fault_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  output logic             clamp_o,
  output logic             halt_o,
  output logic             prst_o,
  output logic             srst_o,
  output logic             irq_o,
  output logic [OFF_W-1:0] off_time_o,
  output logic [CNT_W-1:0] evt_cnt_o,
  output logic [31:0]      status_o
);
  localparam int unsigned MTX_W = N_FLT * N_RESP;

  logic [MTX_W-1:0] mtx_q;
  logic [TMR_W-1:0] len_q [2];
  logic [N_FLT-1:0] flt_s, flt_p, rise, unmask, sticky_q;
  logic [N_RESP-1:0] resp_act, resp_o;
  logic [1:0] rst_out;
  logic tick_1m, tick_100k;

  fr_sync #(.W(N_FLT)) u_sync (.clk_i, .rst_ni, .d_i(fault_i), .q_o(flt_s));
  fr_tick #(.DIV(DIV_1M))   u_t1m   (.clk_i, .rst_ni, .tick_o(tick_1m));
  fr_tick #(.DIV(DIV_100K)) u_t100k (.clk_i, .rst_ni, .tick_o(tick_100k));

  // register port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mtx_q    <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_MTX:  mtx_q    <= wr_data_i[MTX_W-1:0];
        ADDR_PLEN: len_q[0] <= wr_data_i[TMR_W-1:0];
        ADDR_SLEN: len_q[1] <= wr_data_i[TMR_W-1:0];
        default: ;
      endcase
    end
  end

  // mask/map matrix
  always_comb begin
    resp_act = '0;
    for (int i = 0; i < N_FLT; i++) begin
      unmask[i] = |mtx_q[i*N_RESP +: N_RESP];
      for (int j = 0; j < N_RESP; j++)
        resp_act[j] = resp_act[j] | (flt_s[i] & mtx_q[i*N_RESP+j]);
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_rtmr
    fr_rst_timer #(.TW(TMR_W)) u_tmr (
      .clk_i, .rst_ni,
      .act_i (resp_act[RSP_PRST + t]),
      .tick_i(tick_1m),
      .len_i (len_q[t]),
      .rst_o (rst_out[t])
    );
  end

  assign clamp_o = resp_act[RSP_CLAMP];
  assign halt_o  = resp_act[RSP_HALT];
  assign irq_o   = resp_act[RSP_IRQ];
  assign prst_o  = rst_out[0];
  assign srst_o  = rst_out[1];
  assign resp_o  = {irq_o, srst_o, prst_o, halt_o, clamp_o};

  // edge detect, sticky status, event counter
  assign rise = flt_s & ~flt_p;

  logic [CNT_W-1:0] evt_q;
  logic [CNT_W:0]   evt_inc, evt_nxt;
  always_comb begin
    evt_inc = '0;
    for (int i = 0; i < N_FLT; i++)
      evt_inc = evt_inc + (CNT_W+1)'(rise[i] & unmask[i]);
    evt_nxt = {1'b0, evt_q} + evt_inc;
  end

  logic [N_FLT-1:0] clr;
  assign clr = (wr_en_i && wr_addr_i == ADDR_CLR) ? wr_data_i[N_FLT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_p    <= '0;
      sticky_q <= '0;
      evt_q    <= '0;
    end else begin
      flt_p    <= flt_s;
      sticky_q <= (sticky_q & ~clr) | rise;
      evt_q    <= evt_nxt[CNT_W] ? '1 : evt_nxt[CNT_W-1:0];
    end
  end

  // off-line timer
  logic run, run_q;
  logic [OFF_W-1:0] off_q;
  assign run = |(flt_s & unmask) | prst_o | srst_o;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      off_q <= '0;
    end else begin
      run_q <= run;
      if (run && !run_q)                        off_q <= '0;
      else if (run && tick_100k && off_q != '1) off_q <= off_q + 1'b1;
    end
  end

  assign off_time_o = off_q;
  assign evt_cnt_o  = evt_q;
  assign status_o   = 32'({resp_o, sticky_q});
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int unsigned N_FLT = 4,
  parameter int unsigned OFF_W = 24,
  parameter int unsigned CNT_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [1:0]           wr_addr_i,
  input logic [31:0]          wr_data_i,
  input logic [N_FLT-1:0]     fault_s,
  input logic [N_FLT*5-1:0]   mtx,
  input logic                 clamp_o,
  input logic                 prst_o,
  input logic [OFF_W-1:0]     off_time_o,
  input logic [CNT_W-1:0]     evt_cnt_o,
  input logic [31:0]          status_o
);
  logic [N_FLT-1:0] col_clamp, col_prst;
  always_comb
    for (int i = 0; i < N_FLT; i++) begin
      col_clamp[i] = mtx[i*5];
      col_prst[i]  = mtx[i*5+2];
    end

  assert_clamp_mapped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> |(fault_s & col_clamp));

  assert_prst_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prst_o) |-> !(|(fault_s & col_prst)));

  assert_off_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_time_o == $past(off_time_o)) || (off_time_o == $past(off_time_o) + 1'b1)
    || (off_time_o == '0));

  assert_evt_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt_o >= $past(evt_cnt_o));

  assert_sticky_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(status_o[N_FLT-1:0]) & ~status_o[N_FLT-1:0]))
    |-> $past(wr_en_i && wr_addr_i == 2'd3));
endmodule

bind fault_recovery_seq fr_checker #(.N_FLT(N_FLT), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .fault_s(flt_s), .mtx(mtx_q), .clamp_o(clamp_o),
  .prst_o(prst_o), .off_time_o(off_time_o), .evt_cnt_o(evt_cnt_o), .status_o(status_o)
);

// File: tb/sim_fault_recovery_seq.sv
module sim_fault_recovery_seq;
  localparam int OFF_W = 6, CNT_W = 4;

  logic clk = 0, rst_ni = 0;
  logic [3:0] fault_i = '0;
  logic wr_en_i = 0;
  logic [1:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic clamp_o, halt_o, prst_o, srst_o, irq_o;
  logic [OFF_W-1:0] off_time_o;
  logic [CNT_W-1:0] evt_cnt_o;
  logic [31:0] status_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  fault_recovery_seq #(.N_FLT(4), .TMR_W(4), .OFF_W(OFF_W), .CNT_W(CNT_W),
                       .DIV_1M(4), .DIV_100K(8)) u0 (
    .clk_i(clk), .rst_ni, .fault_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .clamp_o, .halt_o, .prst_o, .srst_o, .irq_o, .off_time_o, .evt_cnt_o, .status_o);

  function automatic logic [4:0] resp_vec();
    return {irq_o, srst_o, prst_o, halt_o, clamp_o};
  endfunction
  function automatic int sat_add(int a, int b);
    return (a + b > 15) ? 15 : a + b;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask
  task automatic chk_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(3); rst_ni = 1; cyc(1);
    // R9 reset state
    chk("R9 resp", resp_vec(), 0);
    chk("R9 cnt", evt_cnt_o, 0);
    chk("R9 status", status_o, 0);
    chk("R9 off", off_time_o, 0);

    // R5/R6: two unmasked + one masked rising together
    wr(0, 32'h21);                     // f0,f1 -> clamp; f2,f3 masked
    @(negedge clk); fault_i = 4'b0111;
    cyc(1); chk("R1 not yet", clamp_o, 0);
    cyc(1); chk("R1 visible", clamp_o, 1);
    cyc(1);
    chk("R5 two edges", evt_cnt_o, 2);
    chk("R6 sticky", status_o[3:0], 4'b0111);
    chk("R6 live", status_o[8:4], 5'b00001);
    fault_i = 0; cyc(4);
    chk("R2 released", clamp_o, 0);
    exp_cnt = 2;

    // R7: partial clear
    wr(3, 32'h1);
    chk("R7 clear bit0", status_o[3:0], 4'b0110);
    // R7: clear collides with set of bit0
    @(negedge clk); fault_i = 4'b0001;
    cyc(1);                            // edge1
    @(negedge clk); wr_en_i = 1; wr_addr_i = 3; wr_data_i = 32'h1;   // after edge2
    @(negedge clk); wr_en_i = 0;       // edge3 applied clear and rise
    chk("R7 set wins", status_o[0], 1);
    exp_cnt = sat_add(exp_cnt, 1);
    fault_i = 0; cyc(4);
    wr(3, 32'hF);
    chk("R7 all cleared", status_o[3:0], 0);

    // R3: primary timer len 3, secondary untouched
    wr(0, 32'h04); wr(1, 3); wr(2, 0);
    @(negedge clk); fault_i = 4'b0001;
    cyc(6); exp_cnt = sat_add(exp_cnt, 1);
    chk("R3 active", prst_o, 1);
    fault_i = 0; cyc(2);
    chk("R3 held at clear", prst_o, 1);
    cyc(8); chk("R3 held len", prst_o, 1);
    chk("R3 srst independent", srst_o, 0);
    cyc(20); chk("R3 released", prst_o, 0);
    // R3: len 0 -> one tick
    wr(1, 0);
    @(negedge clk); fault_i = 4'b0001; cyc(6); exp_cnt = sat_add(exp_cnt, 1);
    fault_i = 0; cyc(2);
    chk("R3 zero len held", prst_o, 1);
    cyc(6); chk("R3 zero len released", prst_o, 0);

    // R4 off-line timer
    wr(0, 32'h10);                     // f0 -> irq
    @(negedge clk); fault_i = 4'b0001; cyc(80); exp_cnt = sat_add(exp_cnt, 1);
    fault_i = 0; cyc(10);
    chk_rng("R4 duration", off_time_o, 9, 11);
    cyc(30); chk_rng("R4 retained", off_time_o, 9, 11);
    @(negedge clk); fault_i = 4'b0001; cyc(600); exp_cnt = sat_add(exp_cnt, 1);
    fault_i = 0; cyc(10);
    chk("R4 saturate", off_time_o, 63);
    @(negedge clk); fault_i = 4'b0001; cyc(16); exp_cnt = sat_add(exp_cnt, 1);
    fault_i = 0; cyc(10);
    chk_rng("R4 restart", off_time_o, 1, 3);
    chk("R5 count so far", evt_cnt_o, exp_cnt);

    // random map/mask runs (R1, R2, R5, R6, R8)
    for (int k = 0; k < 14; k++) begin
      logic [4:0] row;
      int f;
      row = 5'($urandom);
      if (k % 4 == 0) row = '0;
      f = $urandom % 4;
      wr(0, 32'(row) << (f * 5));
      wr(1, $urandom % 4); wr(2, $urandom % 4);
      wr(3, 32'hF);
      @(negedge clk); fault_i = 4'(1 << f);
      cyc(1); chk("R1 sync delay", resp_vec(), 0);
      cyc(1); chk("R2 map", resp_vec(), row);
      cyc(1);
      if (row != 0) exp_cnt = sat_add(exp_cnt, 1);
      chk("R5 count", evt_cnt_o, exp_cnt);
      chk("R6 sticky", status_o[3:0], 1 << f);
      chk("R6 live", status_o[8:4], row);
      fault_i = 0; cyc(40);
      chk("R8 idle", resp_vec(), 0);
    end

    // R5 saturation
    wr(0, 32'h01);
    for (int p = 0; p < 20; p++) begin
      @(negedge clk); fault_i = 4'b0001; cyc(3); fault_i = 0; cyc(3);
    end
    cyc(3);
    chk("R5 saturate", evt_cnt_o, 15);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule